// File: doc/BRIEF.md
# Warping envelope generator

This block computes the upper and lower envelopes of a signed fixed-point sequence as it streams in. For each index i, the upper value is the largest sample and the lower value is the smallest sample inside a band of radius r around i. The band is clipped to the sequence bounds [0, n-1] and is not padded. The same hardware serves whichever sequence is fed to it, so a query and a candidate can swap roles without any change to the block. Envelopes of this kind bound the warping path allowed by a band constraint, and a lower-bound stage downstream consumes them.

A frame begins with a one-cycle start pulse that captures the sequence length and the radius. Samples then arrive one per valid/ready beat. Output pairs leave with a valid flag, trailing the input by r samples. After the last sample is accepted, the block emits the remaining r pairs on its own and holds its input ready low while it does so. The radius can be changed at run time up to a compile-time maximum. The history of samples is a shift register that spans the widest band, and two balanced comparator trees reduce it.

Top module: `warp_env_gen`

## Requirements
- R1: With a radius of 0, every upper and lower output equals the sample at the same index.
- R2: The upper output for index i is the maximum of samples max(0,i-r) through min(n-1,i+r), compared as two's-complement signed values.
- R3: The lower output for index i is the minimum over the same clipped window, compared as signed values.
- R4: A frame of length n yields exactly n output pairs, in index order 0 to n-1.
- R5: The pair for index i is valid in the cycle after the clock edge that accepted sample i+r. When i+r > n-1, the pair is valid i+r-n+2 cycles after the edge that accepted the last sample.
- R6: From the edge that accepts the last sample until the r flush pairs have been issued, in_ready_o stays low whatever in_valid_i does, and samples offered in that window affect no output.
- R7: A start pulse abandons any frame in progress. No pair is valid in the cycle after the start edge, no value from the old frame appears later, and length and radius are taken only at the start edge.
- R8: Whenever out_valid_o is high, upper_o is greater than or equal to lower_o as a signed value.
- R9: After reset, and until a start pulse arrives, in_ready_o and out_valid_o stay low.
- R10: A start with length 0 produces no output pairs and leaves in_ready_o low.
- R11: When r >= n-1, every upper output equals the maximum and every lower output equals the minimum of the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens a new frame |
| len_i | input | LEN_W (11) | Frame length n, captured at start |
| radius_i | input | RAD_W (5) | Band radius r, captured at start |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can accept a sample |
| in_data_i | input | SAMPLE_W (16) | Signed input sample |
| out_valid_o | output | 1 | Envelope pair valid |
| upper_o | output | SAMPLE_W (16) | Signed upper envelope |
| lower_o | output | SAMPLE_W (16) | Signed lower envelope |

## Verification
An accepted sample enters the history register at its accepting edge, and its pair is registered one edge later. So the pair for index i is due exactly one cycle after sample i+r is accepted. During the flush, pairs are due on consecutive cycles after the last accept. The bench stamps the cycle count on each accept and on each valid output, then compares every output stamp against this rule and every value against a clipped-window model. The bench samples and drives on the falling edge, so the registers have settled. It waits r+4 cycles after the last accept before counting outputs, and it checks the cycle right after a start edge for a stray pair.

// File: rtl/warp_env_pkg.sv
package warp_env_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_FLUSH
  } phase_e;
endpackage

// File: rtl/warp_env_ctrl.sv
module warp_env_ctrl
  import warp_env_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int RAD_W   = 5,
  parameter int RAD_MAX = 31,
  parameter int STEP_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [RAD_W-1:0] radius_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic             push_o,
  output logic             push_vld_o,
  output logic             emit_o,
  output logic [RAD_W-1:0] rad_o
);
  phase_e              phase_q;
  logic [LEN_W-1:0]    len_q;
  logic [LEN_W-1:0]    in_cnt_q;
  logic [RAD_W-1:0]    rad_q;
  logic [RAD_W-1:0]    flush_q;
  logic [STEP_W-1:0]   step_q;
  logic [RAD_W-1:0]    rad_load;
  logic                accept;
  logic                flush_step;
  logic                last_in;

  assign rad_load   = (int'(radius_i) > RAD_MAX) ? RAD_W'(RAD_MAX) : radius_i;
  assign in_ready_o = (phase_q == ST_FILL) && !start_i;
  assign accept     = in_valid_i && in_ready_o;
  assign flush_step = (phase_q == ST_FLUSH) && !start_i;
  assign push_o     = accept || flush_step;
  assign push_vld_o = accept;
  // a pair leaves once r+1 window steps have been pushed
  assign emit_o     = push_o && (step_q >= STEP_W'(rad_q));
  assign last_in    = (in_cnt_q == len_q - LEN_W'(1));
  assign rad_o      = rad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= ST_IDLE;
      len_q    <= '0;
      in_cnt_q <= '0;
      rad_q    <= '0;
      flush_q  <= '0;
      step_q   <= '0;
    end else if (start_i) begin
      len_q    <= len_i;
      rad_q    <= rad_load;
      flush_q  <= rad_load;
      in_cnt_q <= '0;
      step_q   <= '0;
      phase_q  <= (len_i == '0) ? ST_IDLE : ST_FILL;
    end else begin
      unique case (phase_q)
        ST_FILL: begin
          if (accept) begin
            in_cnt_q <= in_cnt_q + LEN_W'(1);
            step_q   <= step_q + STEP_W'(1);
            if (last_in) phase_q <= (rad_q == '0) ? ST_IDLE : ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          step_q  <= step_q + STEP_W'(1);
          flush_q <= flush_q - RAD_W'(1);
          if (flush_q == RAD_W'(1)) phase_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/warp_env_window.sv
module warp_env_window #(
  parameter int W     = 16,
  parameter int DEPTH = 63,
  parameter int RAD_W = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      push_i,
  input  logic                      push_vld_i,
  input  logic [W-1:0]              din_i,
  input  logic [RAD_W-1:0]          rad_i,
  output logic [DEPTH-1:0][W-1:0]   hist_o,
  output logic [DEPTH-1:0]          sel_o
);
  logic [DEPTH-1:0][W-1:0] hist_q;
  logic [DEPTH-1:0]        vld_q;

  // slot 0 holds the newest step; bubbles during flush enter as invalid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      vld_q  <= '0;
    end else if (clear_i) begin
      vld_q  <= '0;
    end else if (push_i) begin
      hist_q <= {hist_q[DEPTH-2:0], din_i};
      vld_q  <= {vld_q[DEPTH-2:0], push_vld_i};
    end
  end

  assign hist_o = hist_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_sel
    assign sel_o[k] = vld_q[k] && (k <= 2 * int'(rad_i));
  end
endmodule

// File: rtl/warp_env_tree.sv
module warp_env_tree #(
  parameter int W      = 16,
  parameter int N      = 63,
  parameter bit IS_MAX = 1'b1
) (
  input  logic [N-1:0][W-1:0] leaf_i,
  input  logic [N-1:0]        sel_i,
  output logic [W-1:0]        red_o
);
  localparam int LVL = $clog2(N);
  localparam int P   = 1 << LVL;
  localparam logic [W-1:0] IDLE_V = IS_MAX ? {1'b1, {(W-1){1'b0}}}
                                           : {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] node [2*P-1];

  for (genvar k = 0; k < P; k++) begin : g_leaf
    if (k < N) begin : g_real
      assign node[P-1+k] = sel_i[k] ? leaf_i[k] : IDLE_V;
    end else begin : g_pad
      assign node[P-1+k] = IDLE_V;
    end
  end

  for (genvar j = 0; j < P - 1; j++) begin : g_node
    if (IS_MAX) begin : g_max
      assign node[j] = ($signed(node[2*j+1]) > $signed(node[2*j+2])) ? node[2*j+1] : node[2*j+2];
    end else begin : g_min
      assign node[j] = ($signed(node[2*j+1]) < $signed(node[2*j+2])) ? node[2*j+1] : node[2*j+2];
    end
  end

  assign red_o = node[0];
endmodule

// File: rtl/warp_env_gen.sv
module warp_env_gen
  import warp_env_pkg::*;
#(
  parameter int  SAMPLE_W  = 16,
  parameter int  LEN_MAX   = 1024,
  parameter int  RAD_MAX   = 31,
  localparam int LEN_W     = $clog2(LEN_MAX + 1),
  localparam int RAD_W     = $clog2(RAD_MAX + 1),
  localparam int WIN_DEPTH = 2 * RAD_MAX + 1,
  localparam int STEP_W    = LEN_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [RAD_W-1:0]    radius_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_data_i,
  output logic                out_valid_o,
  output logic [SAMPLE_W-1:0] upper_o,
  output logic [SAMPLE_W-1:0] lower_o
);
  logic                               push;
  logic                               push_vld;
  logic                               emit;
  logic [RAD_W-1:0]                   rad;
  logic [WIN_DEPTH-1:0][SAMPLE_W-1:0] hist;
  logic [WIN_DEPTH-1:0]               sel;
  logic [SAMPLE_W-1:0]                win_max;
  logic [SAMPLE_W-1:0]                win_min;
  logic                               emit_q;
  logic                               out_valid_q;
  logic [SAMPLE_W-1:0]                upper_q;
  logic [SAMPLE_W-1:0]                lower_q;

  warp_env_ctrl #(
    .LEN_W  (LEN_W),
    .RAD_W  (RAD_W),
    .RAD_MAX(RAD_MAX),
    .STEP_W (STEP_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .len_i     (len_i),
    .radius_i  (radius_i),
    .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o),
    .push_o    (push),
    .push_vld_o(push_vld),
    .emit_o    (emit),
    .rad_o     (rad)
  );

  warp_env_window #(
    .W    (SAMPLE_W),
    .DEPTH(WIN_DEPTH),
    .RAD_W(RAD_W)
  ) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .push_i    (push),
    .push_vld_i(push_vld),
    .din_i     (in_data_i),
    .rad_i     (rad),
    .hist_o    (hist),
    .sel_o     (sel)
  );

  warp_env_tree #(.W(SAMPLE_W), .N(WIN_DEPTH), .IS_MAX(1'b1)) u_max (
    .leaf_i(hist),
    .sel_i (sel),
    .red_o (win_max)
  );

  warp_env_tree #(.W(SAMPLE_W), .N(WIN_DEPTH), .IS_MAX(1'b0)) u_min (
    .leaf_i(hist),
    .sel_i (sel),
    .red_o (win_min)
  );

  // window settles one edge after the push; register the reduction there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emit_q      <= 1'b0;
      out_valid_q <= 1'b0;
      upper_q     <= '0;
      lower_q     <= '0;
    end else if (start_i) begin
      emit_q      <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      emit_q      <= emit;
      out_valid_q <= emit_q;
      if (emit_q) begin
        upper_q <= win_max;
        lower_q <= win_min;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign upper_o     = upper_q;
  assign lower_o     = lower_q;
endmodule

// File: rtl/warp_env_gen_chk.sv
module warp_env_gen_chk #(
  parameter int SAMPLE_W = 16,
  parameter int LEN_W    = 11,
  parameter int RAD_W    = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [LEN_W-1:0]    len_i,
  input logic [RAD_W-1:0]    radius_i,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                out_valid_o,
  input logic [SAMPLE_W-1:0] upper_o,
  input logic [SAMPLE_W-1:0] lower_o
);
  logic [LEN_W-1:0] frame_len_q;
  logic [RAD_W-1:0] frame_rad_q;
  logic [LEN_W:0]   out_cnt_q;
  logic [LEN_W:0]   acc_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_len_q <= '0;
      frame_rad_q <= '0;
      out_cnt_q   <= '0;
      acc_cnt_q   <= '0;
    end else if (start_i) begin
      frame_len_q <= len_i;
      frame_rad_q <= radius_i;
      out_cnt_q   <= '0;
      acc_cnt_q   <= '0;
    end else begin
      if (out_valid_o) out_cnt_q <= out_cnt_q + 1'b1;
      if (in_valid_i && in_ready_o) acc_cnt_q <= acc_cnt_q + 1'b1;
    end
  end

  // R1
  zero_radius_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && frame_rad_q == '0) |-> (upper_o == lower_o));

  // R8
  env_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($signed(upper_o) >= $signed(lower_o)));

  // R4
  frame_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_cnt_q < {1'b0, frame_len_q}));

  // R6
  flush_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cnt_q == {1'b0, frame_len_q}) |-> !in_ready_o);

  // R7
  start_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !out_valid_o);

  // R10
  empty_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i == '0) |=> !in_ready_o);
endmodule

bind warp_env_gen warp_env_gen_chk #(
  .SAMPLE_W(SAMPLE_W),
  .LEN_W   (LEN_W),
  .RAD_W   (RAD_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .len_i      (len_i),
  .radius_i   (radius_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .upper_o    (upper_o),
  .lower_o    (lower_o)
);

// File: tb/warp_env_gen_tb_top.sv
`timescale 1ns/1ps
module warp_env_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] len_i = '0;
  logic [4:0]  radius_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] in_data_i = '0;
  logic        out_valid_o;
  logic [15:0] upper_o;
  logic [15:0] lower_o;

  always #2 clk_i = ~clk_i;

  warp_env_gen dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .len_i      (len_i),
    .radius_i   (radius_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .out_valid_o(out_valid_o),
    .upper_o    (upper_o),
    .lower_o    (lower_o)
  );

  typedef struct packed {
    int               len;
    int               rad;
    logic [0:7][15:0] smp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8, 1, '{16'd5, -16'd3, 16'd7, 16'd0, 16'd2, -16'd8, 16'd4, 16'd1}},
    '{8, 2, '{16'd100, -16'd200, 16'd300, -16'd400, 16'd500, -16'd600, 16'd700, -16'd800}},
    '{5, 0, '{16'd7, -16'd7, 16'h7fff, 16'h8000, 16'd0, 16'd0, 16'd0, 16'd0}},
    '{3, 4, '{16'd1, 16'd2, 16'd3, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}},
    '{1, 2, '{-16'd5, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}},
    '{8, 3, '{16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8}}
  };

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit post_ov;
  int cur[$];
  int got_up[$];
  int got_lo[$];
  int got_cyc[$];
  int acc_cyc [1024];

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (out_valid_o) begin
      got_up.push_back(int'($signed(upper_o)));
      got_lo.push_back(int'($signed(lower_o)));
      got_cyc.push_back(cyc);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int win_max(int n, int r, int i);
    int lo = (i - r < 0) ? 0 : i - r;
    int hi = (i + r > n - 1) ? n - 1 : i + r;
    int m = cur[lo];
    for (int k = lo; k <= hi; k++) if (cur[k] > m) m = cur[k];
    return m;
  endfunction

  function automatic int win_min(int n, int r, int i);
    int lo = (i - r < 0) ? 0 : i - r;
    int hi = (i + r > n - 1) ? n - 1 : i + r;
    int m = cur[lo];
    for (int k = lo; k <= hi; k++) if (cur[k] < m) m = cur[k];
    return m;
  endfunction

  task automatic start_frame(int n, int r);
    @(negedge clk_i);
    start_i = 1'b1; len_i = 11'(n); radius_i = 5'(r);
    @(negedge clk_i);
    post_ov = out_valid_o;
    start_i = 1'b0;
    // garbage after start must be ignored (R7)
    len_i = 11'd3; radius_i = 5'd7;
    #1;
    got_up.delete(); got_lo.delete(); got_cyc.delete();
  endtask

  task automatic feed(int cnt, bit gaps);
    for (int j = 0; j < cnt; j++) begin
      if (gaps && (j % 3 == 1)) begin
        in_valid_i = 1'b0;
        @(negedge clk_i);
      end
      in_valid_i = 1'b1;
      in_data_i  = 16'(cur[j]);
      while (!in_ready_o) @(negedge clk_i);
      @(negedge clk_i);
      acc_cyc[j] = cyc;
    end
    in_valid_i = 1'b0;
  endtask

  task automatic finish_frame(int n, int r);
    in_valid_i = 1'b1;
    in_data_i  = 16'h7fff;
    for (int k = 0; k < r; k++) begin
      chk(in_ready_o == 1'b0, "R6", int'(in_ready_o), 0);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(got_up.size() == n, "R4", got_up.size(), n);
    for (int i = 0; i < n && i < got_up.size(); i++) begin
      int eu = win_max(n, r, i);
      int el = win_min(n, r, i);
      int due = (i + r <= n - 1) ? acc_cyc[i+r] + 1 : acc_cyc[n-1] + (i + r - n + 1) + 1;
      chk(got_up[i] == eu, (r == 0) ? "R1" : (r >= n - 1) ? "R11" : "R2", got_up[i], eu);
      chk(got_lo[i] == el, (r == 0) ? "R1" : (r >= n - 1) ? "R11" : "R3", got_lo[i], el);
      chk(got_up[i] >= got_lo[i], "R8", got_up[i], got_lo[i]);
      chk(got_cyc[i] == due, "R5", got_cyc[i], due);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9: idle after reset, even with input offered
    chk(in_ready_o == 1'b0, "R9", int'(in_ready_o), 0);
    chk(out_valid_o == 1'b0, "R9", int'(out_valid_o), 0);
    in_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(in_ready_o == 1'b0, "R9", int'(in_ready_o), 0);
    chk(out_valid_o == 1'b0, "R9", int'(out_valid_o), 0);
    in_valid_i = 1'b0;

    for (int v = 0; v < 6; v++) begin
      cur.delete();
      for (int j = 0; j < VECS[v].len; j++) cur.push_back(int'($signed(VECS[v].smp[j])));
      start_frame(VECS[v].len, VECS[v].rad);
      feed(VECS[v].len, v[0]);
      finish_frame(VECS[v].len, VECS[v].rad);
    end

    // widest band on a long frame
    cur.delete();
    for (int j = 0; j < 100; j++) cur.push_back((((j * 37) % 201) - 100) * 150);
    start_frame(100, 31);
    feed(100, 1'b0);
    finish_frame(100, 31);

    // gapped input, mid radius
    cur.delete();
    for (int j = 0; j < 40; j++) cur.push_back(((j * j * 13) % 997) - 498);
    start_frame(40, 5);
    feed(40, 1'b1);
    finish_frame(40, 5);

    // R7: abort mid-frame
    cur.delete();
    for (int j = 0; j < 10; j++) cur.push_back(9000 + j);
    start_frame(10, 3);
    feed(5, 1'b0);
    cur.delete();
    cur.push_back(-3); cur.push_back(8); cur.push_back(-1); cur.push_back(2);
    start_frame(4, 1);
    chk(post_ov == 1'b0, "R7", int'(post_ov), 0);
    feed(4, 1'b0);
    finish_frame(4, 1);

    // R10: empty frame
    start_frame(0, 2);
    in_valid_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(in_ready_o == 1'b0, "R10", int'(in_ready_o), 0);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    chk(got_up.size() == 0, "R10", got_up.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule